// File: doc/BRIEF.md
# Convergent Rounding and Saturation Unit

This block derives a 16-bit rounded value from the upper half of a signed fixed-point accumulator word. The accumulator word has guard bits above its upper half. The bits below the upper half decide the rounding. Exact ties go to the even neighbour, so repeated rounding does not drift in one direction. The result is kept in a dedicated rounding register, and the accumulator word is only read. Integer and fractional data are treated the same way.

The register loads a new value whenever one of two strobes is high on a clock edge. The first strobe comes from the arithmetic pipeline's last stage, after any shift of the accumulator. The second marks a direct write of the accumulator's least significant byte. An enable input selects the overflow behaviour. When it is set, an overflow clamps the result to the largest positive or most negative 16-bit value. When it is clear, the result wraps.

Top module: `rnd_sat_unit`

## Requirements
- R1: While reset is low, and after it is released until the first update, the rounding register reads 0x0000.
- R2: With accumulator bits 15..0 above 0x8000, the loaded value is accumulator bits 31..16 plus one (modulo 2^16 when saturation is off).
- R3: With accumulator bits 15..0 below 0x8000, the loaded value equals accumulator bits 31..16.
- R4: With accumulator bits 15..0 exactly 0x8000, one is added when bit 16 is 1 and nothing is added when bit 16 is 0.
- R5: A high pipeline-stage strobe on a clock edge loads the rounding register.
- R6: A high low-byte-write strobe on a clock edge loads the rounding register in the same way.
- R7: With both strobes low, the rounding register keeps its value whatever the accumulator input does.
- R8: With saturation enabled, a positive overflow of the signed rounded value loads 0x7FFF. Overflow is judged on the whole signed word including guard bits, plus the rounding increment. A value that is in range loads unchanged.
- R9: With saturation enabled, a negative overflow (rounded value below -32768) loads 0x8000. Exactly -32768 is not an overflow.
- R10: With saturation disabled, the loaded value is the low 16 bits of the rounded upper part, so guard bits are ignored and overflow wraps.
- R11: The new value is visible on the output right after the clock edge on which the strobe was high, which is one register of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_i | input | ACC_W (40) | Signed accumulator word, guard bits on top |
| sat_en_i | input | 1 | 1 = clamp on overflow, 0 = wrap |
| stage_stb_i | input | 1 | Pipeline-stage update strobe |
| lsb_wr_i | input | 1 | Accumulator low-byte write strobe |
| rnd_o | output | RES_W (16) | Rounding register |

## Verification
The bench builds the unit with its defaults: a 40-bit accumulator, 16 fraction bits and a 16-bit result. That leaves eight guard bits above bit 31, so the tests can push overflows that exist only in the guard bits into both clamp directions. They also cover a carry out of 0x7FFF caused purely by the rounding increment, and the exact -32768 boundary. Both tie parities and several negative words are tested, and a sweep mixes the two strobes and both saturation settings.

// File: rtl/rnd_sat_pkg.sv
package rnd_sat_pkg;

    // rounding decision taken from the bits below the result field
    typedef enum logic [1:0] {
        DIR_TRUNC     = 2'd0,
        DIR_UP        = 2'd1,
        DIR_TIE_ODD   = 2'd2,
        DIR_TIE_EVEN  = 2'd3
    } rnd_dir_e;

    // range verdict for the rounded upper part
    typedef enum logic [1:0] {
        OVF_NONE = 2'd0,
        OVF_POS  = 2'd1,
        OVF_NEG  = 2'd2
    } ovf_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_sat_pkg::*;
#(
    parameter int FRAC_W = 16
) (
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              keep_lsb_i,
    output logic              inc_o
);

    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

    rnd_dir_e dir;

    always_comb begin
        if (frac_i > HALF) begin
            dir = DIR_UP;
        end else if (frac_i == HALF) begin
            dir = keep_lsb_i ? DIR_TIE_ODD : DIR_TIE_EVEN;
        end else begin
            dir = DIR_TRUNC;
        end
    end

    always_comb begin
        unique case (dir)
            DIR_UP, DIR_TIE_ODD: inc_o = 1'b1;
            default:             inc_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rnd_clamp.sv
module rnd_clamp
    import rnd_sat_pkg::*;
#(
    parameter int UP_W  = 24,
    parameter int RES_W = 16
) (
    input  logic [UP_W-1:0]  hi_i,
    input  logic             inc_i,
    output logic [RES_W-1:0] wrap_o,
    output ovf_e             ovf_o
);

    localparam int SUM_W = UP_W + 1;
    localparam logic signed [SUM_W-1:0] MAX_S = $signed(SUM_W'((64'd1 << (RES_W - 1)) - 64'd1));
    localparam logic signed [SUM_W-1:0] MIN_S = -MAX_S - SUM_W'(1);

    logic signed [SUM_W-1:0] sum_s;

    always_comb begin
        sum_s  = $signed({hi_i[UP_W-1], hi_i}) + $signed({{UP_W{1'b0}}, inc_i});
        wrap_o = sum_s[RES_W-1:0];
    end

    generate
        if (UP_W > RES_W) begin : g_guard
            // guard bits present: range check over the full signed sum
            always_comb begin
                if (sum_s > MAX_S)      ovf_o = OVF_POS;
                else if (sum_s < MIN_S) ovf_o = OVF_NEG;
                else                    ovf_o = OVF_NONE;
            end
        end else begin : g_noguard
            // upper part fits the result: only the increment can overflow
            always_comb begin
                if (sum_s > MAX_S) ovf_o = OVF_POS;
                else               ovf_o = OVF_NONE;
            end
        end
    endgenerate

endmodule

// File: rtl/rnd_sat_unit.sv
module rnd_sat_unit
    import rnd_sat_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int FRAC_W = 16,
    parameter int RES_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_i,
    input  logic             sat_en_i,
    input  logic             stage_stb_i,
    input  logic             lsb_wr_i,
    output logic [RES_W-1:0] rnd_o
);

    localparam int UP_W = ACC_W - FRAC_W;
    localparam logic [RES_W-1:0] POS_LIM = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] NEG_LIM = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic [RES_W-1:0] rnd;
    } state_t;

    state_t st_d, st_q;

    logic             inc;
    logic [RES_W-1:0] wrapped;
    ovf_e             ovf;

    rnd_decide #(.FRAC_W(FRAC_W)) u_decide (
        .frac_i     (acc_i[FRAC_W-1:0]),
        .keep_lsb_i (acc_i[FRAC_W]),
        .inc_o      (inc)
    );

    rnd_clamp #(.UP_W(UP_W), .RES_W(RES_W)) u_clamp (
        .hi_i   (acc_i[ACC_W-1:FRAC_W]),
        .inc_i  (inc),
        .wrap_o (wrapped),
        .ovf_o  (ovf)
    );

    always_comb begin
        st_d = st_q;
        if (stage_stb_i || lsb_wr_i) begin
            if (sat_en_i && ovf == OVF_POS) begin
                st_d.rnd = POS_LIM;
            end else if (sat_en_i && ovf == OVF_NEG) begin
                st_d.rnd = NEG_LIM;
            end else begin
                st_d.rnd = wrapped;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rnd_o = st_q.rnd;

endmodule

// File: rtl/rnd_sat_unit_chk.sv
module rnd_sat_unit_chk #(
    parameter int ACC_W  = 40,
    parameter int FRAC_W = 16,
    parameter int RES_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] acc_i,
    input logic             sat_en_i,
    input logic             stage_stb_i,
    input logic             lsb_wr_i,
    input logic [RES_W-1:0] rnd_o
);

    localparam int UP_W = ACC_W - FRAC_W;
    localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);
    localparam logic signed [UP_W-1:0] MAX_S = $signed(UP_W'((64'd1 << (RES_W - 1)) - 64'd1));
    localparam logic signed [UP_W-1:0] MIN_S = -MAX_S - UP_W'(1);

    logic                   upd;
    logic [RES_W-1:0]       up_bits;
    logic [FRAC_W-1:0]      low_bits;
    logic signed [UP_W-1:0] hi_s;

    assign upd      = stage_stb_i || lsb_wr_i;
    assign up_bits  = acc_i[FRAC_W +: RES_W];
    assign low_bits = acc_i[FRAC_W-1:0];
    assign hi_s     = $signed(acc_i[ACC_W-1:FRAC_W]);

    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_clear_chk: assert (rnd_o == '0);
        end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(rnd_o));

    // R3
    below_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !sat_en_i && low_bits < HALF) |=> rnd_o == $past(up_bits));

    // R2
    above_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !sat_en_i && low_bits > HALF) |=> rnd_o == RES_W'($past(up_bits) + 1'b1));

    // R4
    tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !sat_en_i && low_bits == HALF) |=>
            rnd_o == RES_W'($past(up_bits) + RES_W'($past(up_bits[0]))));

    // R8
    pos_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && sat_en_i && hi_s > MAX_S) |=> rnd_o == {1'b0, {(RES_W-1){1'b1}}});

    // R9
    neg_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && sat_en_i && hi_s < MIN_S) |=> rnd_o == {1'b1, {(RES_W-1){1'b0}}});

endmodule

bind rnd_sat_unit rnd_sat_unit_chk #(
    .ACC_W  (ACC_W),
    .FRAC_W (FRAC_W),
    .RES_W  (RES_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_i       (acc_i),
    .sat_en_i    (sat_en_i),
    .stage_stb_i (stage_stb_i),
    .lsb_wr_i    (lsb_wr_i),
    .rnd_o       (rnd_o)
);

// File: tb/rnd_sat_unit_tb.sv
`timescale 1ns/1ps
module rnd_sat_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] acc = '0;
    logic        sat = 1'b0;
    logic        stage = 1'b0;
    logic        lsbw = 1'b0;
    logic [15:0] rnd;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [15:0] track = 16'h0000;

    typedef struct {
        logic [15:0] exp;
        string       tag;
        int          due;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;

    rnd_sat_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_i       (acc),
        .sat_en_i    (sat),
        .stage_stb_i (stage),
        .lsb_wr_i    (lsbw),
        .rnd_o       (rnd)
    );

    function automatic logic [15:0] model(input logic [39:0] a, input logic s);
        longint v, up, lo, r;
        bit inc;
        v  = longint'($signed(a));
        up = v >>> 16;
        lo = v & 64'hFFFF;
        inc = (lo > 64'h8000) || (lo == 64'h8000 && (up & 1) == 1);
        r = up + (inc ? 1 : 0);
        if (s && r > 32767)  return 16'h7FFF;
        if (s && r < -32768) return 16'h8000;
        return r[15:0];
    endfunction

    task automatic drive(input logic [39:0] a, input logic s, input logic stb,
                         input logic wr, input string tag);
        item_t it;
        @(negedge clk);
        acc = a; sat = s; stage = stb; lsbw = wr;
        if (stb || wr) track = model(a, s);
        it.exp = track; it.tag = tag; it.due = cyc + 1;
        q.push_back(it);
    endtask

    // monitor: compare each due item just after the edge it belongs to
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            n_chk++;
            if (rnd !== it.exp) begin
                n_fail++;
                $display("FAIL %s: rnd=%h expected %h", it.tag, rnd, it.exp);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: rnd=%h expected completion", rnd);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (rnd !== 16'h0000) begin n_fail++; $display("FAIL R1: rnd=%h expected 0000", rnd); end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (rnd !== 16'h0000) begin n_fail++; $display("FAIL R1: rnd=%h expected 0000", rnd); end

        drive(40'h00_1234_9000, 1'b0, 1'b1, 1'b0, "R2 R5 R11");
        drive(40'h00_1234_7FFF, 1'b0, 1'b1, 1'b0, "R3");
        drive(40'h00_1235_8000, 1'b0, 1'b1, 1'b0, "R4 odd");
        drive(40'h00_1234_8000, 1'b0, 1'b1, 1'b0, "R4 even");
        drive(40'hFF_FFFE_C000, 1'b0, 1'b1, 1'b0, "R2 negative");
        drive(40'h00_5555_0000, 1'b0, 1'b0, 1'b0, "R7");
        drive(40'h7F_0000_FFFF, 1'b1, 1'b0, 1'b0, "R7");
        drive(40'h00_0042_0001, 1'b0, 1'b0, 1'b1, "R6");
        drive(40'h00_7FFF_C000, 1'b1, 1'b1, 1'b0, "R8 carry");
        drive(40'h00_7FFF_C000, 1'b0, 1'b1, 1'b0, "R10 carry");
        drive(40'h01_0000_0000, 1'b1, 1'b0, 1'b1, "R8 guard");
        drive(40'h01_0000_0000, 1'b0, 1'b1, 1'b0, "R10 guard");
        drive(40'hFF_7FFF_0000, 1'b1, 1'b1, 1'b0, "R9");
        drive(40'hFF_7FFF_0000, 1'b0, 1'b1, 1'b0, "R10 negative");
        drive(40'hFF_8000_0000, 1'b1, 1'b1, 1'b0, "R9 boundary");
        drive(40'h00_1234_8000, 1'b1, 1'b1, 1'b0, "R8 in range");
        drive(40'h00_7FFF_7FFF, 1'b1, 1'b1, 1'b1, "R8 max kept");

        for (int k = 0; k < 48; k++) begin
            logic [39:0] a;
            a = {8'(k - 24), 16'(k * 4099 + 32760), 16'(k * 1733 + 32700)};
            drive(a, k[0], k[1] | k[2], k[2], "R11 sweep");
        end

        drive(40'h12_3456_789A, 1'b0, 1'b0, 1'b0, "R7 final");
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule